// File: doc/BRIEF.md
# Sound Generator Host Bus Interface

This block sits between a host microcontroller and a programmable sound generator. The host drives two function-select inputs that pick one of four bus operations: idle, read the selected register, write the selected register, or load a new register address. The address stays latched, so a single address load can be followed by any number of reads and writes to the same register. The block owns the sixteen-entry register file. Each entry keeps only the bits that its function uses, and every other bit reads back as zero.

The 8-bit data bus is split into an input, an output and an output-enable, so a pad ring or a host-side tristate can merge them. An access counts only when the active-high and the active-low chip enables are both asserted. The block also runs a free prescaler on the master clock. It emits one-cycle enable strobes at 1/16 and 1/256 of the clock rate for the downstream generators, plus a one-cycle strobe after every write to the envelope-shape register so that the envelope can restart.

Top module: `psg_bus_if`

## Requirements
- R1: After an active-low reset, every register holds 0, the latched address is 0, `d_oe` is 0, and `shape_wr_stb` is 0.
- R2: The address-load operation (`fn_dir`=1, `fn_sel`=1) latches `d_in[3:0]` at the clock edge and ignores `d_in[7:4]`. The address is kept through any number of later reads and writes until the next address load.
- R3: The write operation (`fn_dir`=1, `fn_sel`=0) stores `d_in`, masked to the register's writable bits, into the addressed register at the clock edge.
- R4: During the read operation (`fn_dir`=0, `fn_sel`=1), `d_oe` is 1 and `d_out` shows the addressed register in the same cycle. At all other times `d_oe` is 0 and `d_out` is 0.
- R5: The writable widths are: registers 1, 3, 5 and 13 keep bits [3:0]; registers 6, 8, 9 and 10 keep bits [4:0]; registers 0, 2, 4, 7, 11, 12, 14 and 15 keep all 8 bits. Bits outside these widths always read 0.
- R6: An operation takes effect only when `ce_hi`=1 and `ce_lo_n`=0. Otherwise a write or address load changes nothing, and a read leaves `d_oe` at 0.
- R7: `tick_lo` is a one-cycle strobe that repeats every 16 clocks. The first one comes in the 16th cycle after reset is released, which is the cycle after the 15th rising edge.
- R8: `tick_hi` is a one-cycle strobe that repeats every 256 clocks. It always coincides with a `tick_lo` strobe.
- R9: `shape_wr_stb` is high for exactly the one cycle after a qualified write to register 13, and it stays low after writes to any other register.
- R10: `reg_all[8*i+7:8*i]` continuously shows register i with its unused bits at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_hi | input | 1 | Active-high chip enable |
| ce_lo_n | input | 1 | Active-low chip enable |
| fn_dir | input | 1 | Bus function select, direction bit |
| fn_sel | input | 1 | Bus function select, companion bit |
| d_in | input | 8 | Data bus input from the host |
| d_out | output | 8 | Data bus output to the host |
| d_oe | output | 1 | Data bus output enable |
| reg_all | output | 128 | All sixteen registers, flattened, for the generators |
| shape_wr_stb | output | 1 | One-cycle pulse after a write to register 13 |
| tick_lo | output | 1 | Enable strobe at clock / 16 |
| tick_hi | output | 1 | Enable strobe at clock / 256 |

## Verification
A corrupted address latch shows up on the next read, because `d_out` then presents a different register. It shows up one cycle after the next write, because the change appears at the wrong byte of `reg_all`. A bad mask or a missed write shows up in `reg_all` right after the clock edge that should have stored the value. A prescaler fault shows up as a strobe spacing other than 16 or 256 cycles, which is detectable within one period of `tick_hi`.

// File: rtl/psg_bus_pkg.sv
package psg_bus_pkg;

    localparam int NREG = 16;
    localparam int AW   = $clog2(NREG);
    localparam int DW   = 8;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_ADDR  = 2'b11
    } bus_op_e;

    // Writable bits for each register index
    function automatic logic [DW-1:0] wmask(input logic [AW-1:0] idx);
        case (idx)
            4'd1, 4'd3, 4'd5, 4'd13: wmask = 8'h0F;
            4'd6, 4'd8, 4'd9, 4'd10: wmask = 8'h1F;
            default:                 wmask = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/psg_cmd_decode.sv
module psg_cmd_decode
    import psg_bus_pkg::*;
(
    input  logic    ce_hi,
    input  logic    ce_lo_n,
    input  logic    fn_dir,
    input  logic    fn_sel,
    output bus_op_e op
);
    logic sel_ok;

    always_comb begin
        sel_ok = ce_hi & ~ce_lo_n;
        op     = sel_ok ? bus_op_e'({fn_dir, fn_sel}) : OP_IDLE;
    end
endmodule

// File: rtl/psg_tick_gen.sv
module psg_tick_gen #(
    parameter int DIV_LO = 16,
    parameter int DIV_HI = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_lo,
    output logic tick_hi
);
    localparam int CW = $clog2(DIV_HI);
    localparam int LW = $clog2(DIV_LO);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CW'(1);
        tick_lo  = &st_q.cnt[LW-1:0];
        tick_hi  = &st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/psg_reg_bank.sv
module psg_reg_bank
    import psg_bus_pkg::*;
#(
    parameter int SHAPE_IDX = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bus_op_e            op,
    input  logic [DW-1:0]      d_in,
    output logic [AW-1:0]      addr,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] reg_all,
    output logic               shape_stb
);
    typedef struct packed {
        logic [AW-1:0]                addr;
        logic [NREG-1:0][DW-1:0]      regs;
        logic                         stb;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        case (op)
            OP_ADDR:  st_d.addr = d_in[AW-1:0];
            OP_WRITE: begin
                st_d.regs[st_q.addr] = d_in & wmask(st_q.addr);
                st_d.stb             = (st_q.addr == AW'(SHAPE_IDX));
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr      = st_q.addr;
    assign rd_data   = st_q.regs[st_q.addr];
    assign shape_stb = st_q.stb;

    for (genvar i = 0; i < NREG; i++) begin : g_flat
        assign reg_all[i*DW +: DW] = st_q.regs[i];
    end
endmodule

// File: rtl/psg_bus_if.sv
module psg_bus_if
    import psg_bus_pkg::*;
#(
    parameter int DIV_LO = 16,
    parameter int DIV_HI = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_hi,
    input  logic         ce_lo_n,
    input  logic         fn_dir,
    input  logic         fn_sel,
    input  logic [7:0]   d_in,
    output logic [7:0]   d_out,
    output logic         d_oe,
    output logic [127:0] reg_all,
    output logic         shape_wr_stb,
    output logic         tick_lo,
    output logic         tick_hi
);
    bus_op_e       op;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] rd_data;

    psg_cmd_decode u_dec (
        .ce_hi   (ce_hi),
        .ce_lo_n (ce_lo_n),
        .fn_dir  (fn_dir),
        .fn_sel  (fn_sel),
        .op      (op)
    );

    psg_reg_bank #(.SHAPE_IDX(13)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .d_in      (d_in),
        .addr      (cur_addr),
        .rd_data   (rd_data),
        .reg_all   (reg_all),
        .shape_stb (shape_wr_stb)
    );

    psg_tick_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_lo (tick_lo),
        .tick_hi (tick_hi)
    );

    always_comb begin
        d_oe  = (op == OP_READ);
        d_out = d_oe ? rd_data : '0;
    end
endmodule

// File: rtl/psg_bus_chk.sv
module psg_bus_chk
    import psg_bus_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         ce_hi,
    input logic         ce_lo_n,
    input logic         fn_dir,
    input logic         fn_sel,
    input logic [7:0]   d_in,
    input logic [7:0]   d_out,
    input logic         d_oe,
    input logic [127:0] reg_all,
    input logic         shape_wr_stb,
    input logic         tick_lo,
    input logic         tick_hi,
    input logic [3:0]   addr
);
    function automatic logic [127:0] all_masks();
        for (int i = 0; i < NREG; i++) all_masks[i*DW +: DW] = wmask(AW'(i));
    endfunction

    localparam logic [127:0] ALLMASK = all_masks();

    logic sel_ok, wr_ok, ld_ok;
    assign sel_ok = ce_hi & ~ce_lo_n;
    assign wr_ok  = sel_ok & fn_dir & ~fn_sel;
    assign ld_ok  = sel_ok & fn_dir & fn_sel;

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ok |=> $stable(addr));

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> reg_all[int'($past(addr))*DW +: DW] == ($past(d_in) & wmask($past(addr))));

    // R4
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !d_oe |-> d_out == 8'h00);

    // R5
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_all & ~ALLMASK) == '0);

    // R6
    no_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok |=> $stable(reg_all) && $stable(addr));

    // R7
    tick_lo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_lo |=> !tick_lo);

    // R8
    tick_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_hi |-> tick_lo);

    // R9
    shape_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok && addr == 4'd13 |=> shape_wr_stb);
endmodule

bind psg_bus_if psg_bus_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_hi        (ce_hi),
    .ce_lo_n      (ce_lo_n),
    .fn_dir       (fn_dir),
    .fn_sel       (fn_sel),
    .d_in         (d_in),
    .d_out        (d_out),
    .d_oe         (d_oe),
    .reg_all      (reg_all),
    .shape_wr_stb (shape_wr_stb),
    .tick_lo      (tick_lo),
    .tick_hi      (tick_hi),
    .addr         (cur_addr)
);

// File: tb/psg_bus_if_tb.sv
module psg_bus_if_tb;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         ce_hi = 1, ce_lo_n = 0, fn_dir = 0, fn_sel = 0;
    logic [7:0]   d_in = 0;
    logic [7:0]   d_out;
    logic         d_oe;
    logic [127:0] reg_all;
    logic         shape_wr_stb, tick_lo, tick_hi;
    int ncmp = 0, nbad = 0;

    always #4 clk = ~clk;

    psg_bus_if u_dut (
        .clk(clk), .rst_n(rst_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
        .fn_dir(fn_dir), .fn_sel(fn_sel), .d_in(d_in), .d_out(d_out),
        .d_oe(d_oe), .reg_all(reg_all), .shape_wr_stb(shape_wr_stb),
        .tick_lo(tick_lo), .tick_hi(tick_hi)
    );

    function automatic logic [7:0] bmask(input int i);
        if (i == 1 || i == 3 || i == 5 || i == 13) return 8'h0F;
        if (i == 6 || i == 8 || i == 9 || i == 10) return 8'h1F;
        return 8'hFF;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic bus_addr(input logic [7:0] v);
        fn_dir = 1; fn_sel = 1; d_in = v;
        @(negedge clk);
        fn_dir = 0; fn_sel = 0;
    endtask

    task automatic bus_write(input logic [7:0] v);
        fn_dir = 1; fn_sel = 0; d_in = v;
        @(negedge clk);
        fn_dir = 0; fn_sel = 0;
    endtask

    task automatic bus_read(output logic [7:0] v, output logic oe);
        fn_dir = 0; fn_sel = 1;
        #1;
        v = d_out; oe = d_oe;
        @(negedge clk);
        fn_dir = 0; fn_sel = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v; logic oe;
        do_reset();
        chk("R1 oe", d_oe, 0);
        chk("R1 shape", shape_wr_stb, 0);
        chk("R1 regs", reg_all == '0, 1);
        bus_read(v, oe);
        chk("R1 addr0 read", v, 0);
    endtask

    task automatic t_write_read();
        logic [7:0] v; logic oe;
        bus_addr(8'h00); bus_write(8'hA5);
        chk("R3 reg0 byte", reg_all[7:0], 8'hA5);
        bus_read(v, oe);
        chk("R4 read data", v, 8'hA5);
        chk("R4 read oe", oe, 1);
        bus_addr(8'h07); bus_write(8'h11);
        bus_read(v, oe); chk("R2 sticky 1", v, 8'h11);
        bus_write(8'h22);
        bus_read(v, oe); chk("R2 sticky 2", v, 8'h22);
        chk("R10 reg7 byte", reg_all[7*8 +: 8], 8'h22);
        chk("R10 reg0 kept", reg_all[7:0], 8'hA5);
        bus_addr(8'hF4); bus_write(8'h66);
        chk("R2 high nibble ignored", reg_all[4*8 +: 8], 8'h66);
    endtask

    task automatic t_masks();
        logic [7:0] v; logic oe;
        for (int i = 0; i < 16; i++) begin
            bus_addr(8'(i)); bus_write(8'hFF);
            bus_read(v, oe);
            chk($sformatf("R5 mask reg%0d", i), v, bmask(i));
            chk($sformatf("R10 flat reg%0d", i), reg_all[i*8 +: 8], bmask(i));
        end
    endtask

    task automatic t_idle();
        fn_dir = 0; fn_sel = 0; #1;
        chk("R4 idle oe", d_oe, 0);
        chk("R4 idle data", d_out, 0);
        @(negedge clk);
    endtask

    task automatic t_chip_en();
        logic [7:0] v; logic oe;
        bus_addr(8'h02); bus_write(8'h3C);
        ce_hi = 0; bus_write(8'h55); ce_hi = 1;
        chk("R6 ce_hi low write", reg_all[2*8 +: 8], 8'h3C);
        ce_lo_n = 1; bus_addr(8'h0B); ce_lo_n = 0;
        bus_read(v, oe);
        chk("R6 ce_lo_n high addr", v, 8'h3C);
        ce_lo_n = 1; bus_read(v, oe); ce_lo_n = 0;
        chk("R6 read oe off", oe, 0);
    endtask

    task automatic t_shape();
        bus_addr(8'h0C);
        fn_dir = 1; fn_sel = 0; d_in = 8'h09; @(negedge clk); fn_dir = 0;
        chk("R9 no strobe reg12", shape_wr_stb, 0);
        bus_addr(8'h0D);
        fn_dir = 1; fn_sel = 0; d_in = 8'h0A; @(negedge clk); fn_dir = 0;
        chk("R9 strobe high", shape_wr_stb, 1);
        @(negedge clk);
        chk("R9 strobe one cycle", shape_wr_stb, 0);
    endtask

    task automatic t_ticks();
        int first = -1, last_lo = -1, last_hi = -1, gap_lo_bad = 0, gap_hi = 0, nhi = 0;
        do_reset();
        for (int i = 1; i <= 600; i++) begin
            @(negedge clk);
            if (tick_lo) begin
                if (first < 0) first = i;
                if (last_lo >= 0 && i - last_lo != 16) gap_lo_bad++;
                last_lo = i;
            end
            if (tick_hi) begin
                nhi++;
                if (!tick_lo) gap_lo_bad++;
                if (last_hi >= 0) gap_hi = i - last_hi;
                last_hi = i;
            end
        end
        chk("R7 first tick", first, 15);
        chk("R7 spacing", gap_lo_bad, 0);
        chk("R8 first hi", last_hi - 256, 255);
        chk("R8 spacing", gap_hi, 256);
        chk("R8 count", nhi, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_write_read();
        t_idle();
        t_masks();
        t_chip_en();
        t_shape();
        t_ticks();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end
endmodule